// File: doc/BRIEF.md
# Video Timing Flag Generator

This block sits on a 10-bit parallel digital video word stream, one word per pixel clock when the enable is high. It searches the stream for timing reference sequences. Each sequence is a three-word preamble followed by a flag word. From the flag words it derives three status outputs: field parity, vertical blanking and horizontal blanking. It also raises an active-low load strobe, one clock wide, each time a start-of-active-video sequence leaves the block. The strobe is meant to drive the write side of a downstream line FIFO.

The stream passes through a short internal delay line before it reaches `vid_out`. Because of this delay, a status change can line up with the first preamble word of the sequence that caused it, even though the sequence can only be recognised once its last word has arrived. A static configuration input selects how the horizontal flag is formed. In one mode it covers the whole blanking span, including both timing sequences. In the other it copies the blanking bit carried in the flag words.

Top module: `trs_timing_flags`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `vid_out` is 000h, `f_out`, `v_out` and `h_out` are 0, and `fifo_ld_n` is 1.
- R2: Each clock edge with `vid_en` high shifts one word in. After such an edge, `vid_out` holds the word accepted three enabled edges before the newest one, or 000h if fewer words have been accepted since reset. Edges with `vid_en` low change neither `vid_out` nor the recognition history.
- R3: A timing sequence is recognised on an enabled edge that accepts a word with bit 9 set, provided the three words accepted before it were 3FFh, 000h and 000h in that order. In the flag word, bit 8 is the field bit, bit 7 is the vertical bit and bit 6 is the horizontal bit. A horizontal bit of 1 marks end of active video, and 0 marks start of active video. A word with bit 9 clear after the same preamble is not a sequence.
- R4: `f_out` takes the field bit of a recognised sequence on the same edge that the sequence's 3FFh reaches `vid_out`, and holds it until the next recognised sequence. A value of 0 means field one or progressive scan.
- R5: `v_out` takes the vertical bit of a recognised sequence on the same edge as R4, and holds it until the next recognised sequence.
- R6: With `hmode` = 0, `h_out` rises on the edge where the 3FFh of an end-of-active sequence reaches `vid_out`. It falls on the edge where the word after the start-of-active flag word reaches `vid_out`.
- R7: With `hmode` = 1, `h_out` equals the horizontal bit of the latest recognised sequence, and changes on the edge where that sequence's 3FFh reaches `vid_out`.
- R8: `fifo_ld_n` is 0 for exactly one clock, starting at the edge where a start-of-active flag word reaches `vid_out`, and is 1 at all other times. End-of-active sequences never pull it low.
- R9: With `hmode` = 0, if an end-of-active sequence is recognised on the same edge as the R6 fall is due (a line with no active words), `h_out` stays high.
- R10: A change of `hmode` selects the other horizontal rule at once, whether or not `vid_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_en | input | 1 | Word valid / clock enable |
| vid_in | input | 10 | Incoming video word |
| hmode | input | 1 | Horizontal flag rule: 0 whole blanking span, 1 copy of flag bit |
| vid_out | output | 10 | Delayed video word |
| f_out | output | 1 | Field two indicator |
| v_out | output | 1 | Vertical blanking indicator |
| h_out | output | 1 | Horizontal blanking indicator |
| fifo_ld_n | output | 1 | Active-low load strobe at start of active video |

## Verification
Two events can land on the same edge: the end of the horizontal blanking countdown after a start-of-active sequence, and the recognition of the next end-of-active sequence. This happens when a line carries zero active words, so the next preamble follows the start-of-active flag word directly. The bench sends such lines in the whole-span mode, some of them with enable stalls inside. A behavioural model that processes the fall before the rise predicts that `h_out` stays high and that the strobe still fires. The output is compared with that model on every clock.

// File: rtl/trs_flags_pkg.sv
package trs_flags_pkg;

    localparam int VID_W    = 10;
    localparam int MARK_BIT = VID_W - 1;

    typedef logic [VID_W-1:0] vid_word_t;

    localparam vid_word_t WORD_ONES = '1;
    localparam vid_word_t WORD_ZERO = '0;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    typedef enum logic [1:0] {
        TRS_NONE = 2'd0,
        TRS_EAV  = 2'd1,
        TRS_SAV  = 2'd2
    } trs_kind_t;

    // upper four bits of a flag word: {mark, f, v, h}
    function automatic trs_flags_t decode_xyz(input logic [3:0] hi);
        trs_flags_t r;
        r.f = hi[2];
        r.v = hi[1];
        r.h = hi[0];
        return r;
    endfunction

    function automatic trs_kind_t classify(input logic hdr_ok, input logic [3:0] hi);
        if (!hdr_ok || !hi[3]) return TRS_NONE;
        return hi[0] ? TRS_EAV : TRS_SAV;
    endfunction

endpackage

// File: rtl/trs_delay_line.sv
module trs_delay_line
    import trs_flags_pkg::*;
#(
    parameter int TRS_LEN = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  vid_word_t                  din,
    output vid_word_t [TRS_LEN-1:0]    taps
);

    vid_word_t stage_q [TRS_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TRS_LEN; i++) stage_q[i] <= WORD_ZERO;
        end else if (en) begin
            stage_q[0] <= din;
            for (int i = 1; i < TRS_LEN; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < TRS_LEN; g++) begin : g_tap
            assign taps[g] = stage_q[g];
        end
    endgenerate

endmodule

// File: rtl/trs_detect.sv
module trs_detect
    import trs_flags_pkg::*;
#(
    parameter int TRS_LEN = 4
) (
    input  logic                       en,
    input  logic [3:0]                 xyz_hi,
    input  vid_word_t [TRS_LEN-2:0]    hdr,
    output trs_kind_t                  kind,
    output trs_flags_t                 flags
);

    localparam int HDR_N = TRS_LEN - 1;

    logic [HDR_N-1:0] hdr_ok;

    // oldest header word must be all ones, the rest all zeros
    generate
        for (genvar k = 0; k < HDR_N; k++) begin : g_hdr
            if (k == HDR_N - 1) begin : g_ones
                assign hdr_ok[k] = (hdr[k] == WORD_ONES);
            end else begin : g_zero
                assign hdr_ok[k] = (hdr[k] == WORD_ZERO);
            end
        end
    endgenerate

    always_comb begin
        flags = decode_xyz(xyz_hi);
        kind  = classify(en && (&hdr_ok), xyz_hi);
    end

endmodule

// File: rtl/trs_hblank.sv
module trs_hblank
    import trs_flags_pkg::*;
#(
    parameter int TRS_LEN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  trs_kind_t kind,
    output logic      h_span,
    output logic      ld_n
);

    localparam int CNT_W = $clog2(TRS_LEN + 1);
    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_LOAD   = cnt_t'(TRS_LEN);
    localparam cnt_t CNT_STROBE = cnt_t'(2);
    localparam cnt_t CNT_FALL   = cnt_t'(1);

    cnt_t cnt_q;
    logic span_q;
    logic ld_n_q;
    logic fall;
    logic rise;

    assign fall = en && (cnt_q == CNT_FALL);
    assign rise = (kind == TRS_EAV);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            span_q <= 1'b0;
            ld_n_q <= 1'b1;
        end else begin
            ld_n_q <= !(en && (cnt_q == CNT_STROBE));
            if (kind == TRS_SAV)       cnt_q <= CNT_LOAD;
            else if (kind == TRS_EAV)  cnt_q <= '0;
            else if (en && cnt_q != '0) cnt_q <= cnt_q - cnt_t'(1);
            if (rise)      span_q <= 1'b1;
            else if (fall) span_q <= 1'b0;
        end
    end

    assign h_span = span_q;
    assign ld_n   = ld_n_q;

endmodule

// File: rtl/trs_timing_flags.sv
module trs_timing_flags
    import trs_flags_pkg::*;
#(
    parameter int TRS_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        vid_en,
    input  logic [9:0]  vid_in,
    input  logic        hmode,
    output logic [9:0]  vid_out,
    output logic        f_out,
    output logic        v_out,
    output logic        h_out,
    output logic        fifo_ld_n
);

    vid_word_t [TRS_LEN-1:0] taps;
    trs_kind_t               kind;
    trs_flags_t              xyz_flags;
    trs_flags_t              flags_q;
    logic                    h_span;

    trs_delay_line #(.TRS_LEN(TRS_LEN)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .en   (vid_en),
        .din  (vid_in),
        .taps (taps)
    );

    trs_detect #(.TRS_LEN(TRS_LEN)) u_detect (
        .en     (vid_en),
        .xyz_hi (vid_in[MARK_BIT -: 4]),
        .hdr    (taps[TRS_LEN-2:0]),
        .kind   (kind),
        .flags  (xyz_flags)
    );

    trs_hblank #(.TRS_LEN(TRS_LEN)) u_hblank (
        .clk    (clk),
        .rst    (rst),
        .en     (vid_en),
        .kind   (kind),
        .h_span (h_span),
        .ld_n   (fifo_ld_n)
    );

    always_ff @(posedge clk) begin
        if (rst)                   flags_q <= '0;
        else if (kind != TRS_NONE) flags_q <= xyz_flags;
    end

    assign vid_out = taps[TRS_LEN-1];
    assign f_out   = flags_q.f;
    assign v_out   = flags_q.v;
    assign h_out   = hmode ? flags_q.h : h_span;

endmodule

// File: rtl/trs_flags_chk.sv
module trs_flags_chk (
    input logic       clk,
    input logic       rst,
    input logic       hmode,
    input logic [9:0] vid_out,
    input logic       f_out,
    input logic       v_out,
    input logic       h_out,
    input logic       fifo_ld_n
);

    AST_LD_SINGLE: assert property (@(posedge clk) disable iff (rst) !fifo_ld_n |=> fifo_ld_n); // R8
    AST_LD_ON_SAV: assert property (@(posedge clk) disable iff (rst) !fifo_ld_n |-> (vid_out[9] && !vid_out[6])); // R8
    AST_F_ON_TRS: assert property (@(posedge clk) disable iff (rst) !$stable(f_out) |-> (vid_out == 10'h3FF)); // R4
    AST_V_ON_TRS: assert property (@(posedge clk) disable iff (rst) !$stable(v_out) |-> (vid_out == 10'h3FF)); // R5
    AST_SPAN_RISE: assert property (@(posedge clk) disable iff (rst) ($rose(h_out) && !hmode && $past(!hmode)) |-> (vid_out == 10'h3FF)); // R6
    AST_COPY_CHANGE: assert property (@(posedge clk) disable iff (rst) (hmode && $past(hmode) && !$stable(h_out)) |-> (vid_out == 10'h3FF)); // R7

endmodule

bind trs_timing_flags trs_flags_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hmode     (hmode),
    .vid_out   (vid_out),
    .f_out     (f_out),
    .v_out     (v_out),
    .h_out     (h_out),
    .fifo_ld_n (fifo_ld_n)
);

// File: tb/tb_trs_timing_flags.sv
module tb_trs_timing_flags;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vid_en = 1'b0;
    logic [9:0] vid_in = 10'h000;
    logic       hmode = 1'b0;
    logic [9:0] vid_out;
    logic       f_out, v_out, h_out, fifo_ld_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string sect = "R1";

    always #10 clk = ~clk;

    trs_timing_flags dut (
        .clk       (clk),
        .rst       (rst),
        .vid_en    (vid_en),
        .vid_in    (vid_in),
        .hmode     (hmode),
        .vid_out   (vid_out),
        .f_out     (f_out),
        .v_out     (v_out),
        .h_out     (h_out),
        .fifo_ld_n (fifo_ld_n)
    );

    // behavioural reference
    logic [9:0] q[$];
    int         n_acc;
    int         sav_at;
    logic [9:0] m_vout;
    logic       m_f, m_v, m_hb, m_h0, m_ld_n;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            n_acc = -1; sav_at = -1;
            m_vout = 10'h000; m_f = 0; m_v = 0; m_hb = 0; m_h0 = 0; m_ld_n = 1;
        end else begin
            m_ld_n = 1;
            if (vid_en) begin
                bit det;
                n_acc++;
                q.push_back(vid_in);
                if (q.size() > 4) void'(q.pop_front());
                m_vout = (q.size() == 4) ? q[0] : 10'h000;
                det = (q.size() == 4) && q[0] == 10'h3FF && q[1] == 0 && q[2] == 0 && vid_in[9];
                if (sav_at >= 0 && n_acc == sav_at + 3) m_ld_n = 0;
                if (sav_at >= 0 && n_acc == sav_at + 4) begin m_h0 = 0; sav_at = -1; end
                if (det) begin
                    m_f = vid_in[8]; m_v = vid_in[7]; m_hb = vid_in[6];
                    if (m_hb) begin m_h0 = 1; sav_at = -1; end
                    else sav_at = n_acc;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, sect, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 vid_out", vid_out, m_vout);
            chk("R4 f_out", {9'd0, f_out}, {9'd0, m_f});
            chk("R5 v_out", {9'd0, v_out}, {9'd0, m_v});
            if (hmode) chk("R7 h_out", {9'd0, h_out}, {9'd0, m_hb});
            else       chk("R6 h_out", {9'd0, h_out}, {9'd0, m_h0});
            chk("R8 fifo_ld_n", {9'd0, fifo_ld_n}, {9'd0, m_ld_n});
        end
    end

    function automatic logic [9:0] xyz(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    task automatic put(input logic [9:0] w);
        @(negedge clk);
        vid_in = w; vid_en = 1'b1;
    endtask

    task automatic gap(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            vid_en = 1'b0; vid_in = 10'h155;
        end
    endtask

    task automatic trs(input logic f, input logic v, input logic h, input bit stall);
        put(10'h3FF); if (stall) gap(1);
        put(10'h000); put(10'h000); if (stall) gap(2);
        put(xyz(f, v, h)); if (stall) gap(1);
    endtask

    task automatic line(input logic f, input logic v, input int nblank, input int nact, input bit stall);
        trs(f, v, 1'b1, stall);
        for (int i = 0; i < nblank; i++) put((i % 2) ? 10'h040 : 10'h200);
        trs(f, v, 1'b0, stall);
        for (int i = 0; i < nact; i++) begin
            put(10'h100 + 10'(i));
            if (stall && i == 1) gap(1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        sect = "R1";
        checks++;
        if (vid_out !== 0 || f_out !== 0 || v_out !== 0 || h_out !== 0 || fifo_ld_n !== 1) begin
            fails++;
            $display("FAIL R1 actual=%h%b%b%b%b expected=0000001", vid_out, f_out, v_out, h_out, fifo_ld_n);
        end
        @(negedge clk); rst = 1'b0;

        sect = "R6 progressive";
        for (int l = 0; l < 3; l++) line(0, 1, 4, 6, 0);
        for (int l = 0; l < 3; l++) line(0, 0, 3, 8, 0);

        sect = "R2 stalls";
        for (int l = 0; l < 3; l++) line(0, 0, 2, 5, 1);

        sect = "R4 field two";
        for (int l = 0; l < 2; l++) line(1, 1, 3, 4, 0);
        for (int l = 0; l < 2; l++) line(1, 0, 3, 4, 1);

        sect = "R3 non-sequence header";
        put(10'h3FF); put(10'h000); put(10'h000); put(10'h1C0);
        put(10'h3FF); put(10'h000); put(10'h3FF); put(10'h000); put(10'h000); put(10'h0C0);
        for (int i = 0; i < 6; i++) put(10'h123);

        sect = "R9 empty line";
        line(0, 0, 2, 0, 0);
        line(0, 0, 2, 0, 1);
        line(0, 0, 0, 0, 0);
        line(0, 0, 2, 3, 0);

        sect = "R7 copy mode";
        @(negedge clk); hmode = 1'b1; vid_en = 1'b0;
        for (int l = 0; l < 3; l++) line(0, l[0], 3, 5, l == 1);

        sect = "R10 mode switch";
        gap(2);
        @(negedge clk); hmode = 1'b0;
        gap(2);
        @(negedge clk); hmode = 1'b1;
        gap(2);
        trs(0, 0, 1'b0, 0);
        put(10'h111);
        @(negedge clk); hmode = 1'b0; vid_en = 1'b0;
        gap(1);
        @(negedge clk); hmode = 1'b1;
        put(10'h112); put(10'h113); put(10'h114);
        @(negedge clk); hmode = 1'b0; vid_en = 1'b0;
        line(0, 0, 2, 4, 0);
        for (int i = 0; i < 6; i++) put(10'h040);
        gap(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule